// File: doc/BRIEF.md
# Row Activation Hammer Tracker

This block sits beside the command path of one DRAM bank and watches every row activation. A small table remembers the rows that have been opened most often in the current refresh window. When a remembered row is opened a programmable number of times, the block asks the command scheduler for targeted refreshes of the two physically adjacent rows. This restores their charge before repeated disturbance can flip their bits.

Targeted refreshes are themselves row openings. Each refresh the scheduler accepts is fed back into the table and counted against the refreshed row. A flood of mitigation refreshes aimed at one victim therefore protects the rows two steps away from the original aggressor. Counts persist while other rows are opened, so an aggressor cannot hide behind interleaved decoy accesses. Every count is cleared by the periodic window tick.

Requests leave through a four-entry queue with a valid/ready handshake. A request that finds the queue full is dropped, and a sticky error flag records the drop.

Top module: `rht_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_valid` and `overflow_err` are low, and every table entry holds row 0 with count 0.
- R2: Each activation increments the count of its row. When the incremented count is greater than or equal to `threshold`, the count becomes 0 and requests for row-1 and then row+1 are queued, in that order, to appear on `req_row` from the next cycle.
- R3: Counts of up to 16 tracked rows persist across activations of other rows, so an aggressor interleaved with decoy rows still reaches the threshold.
- R4: An activation of an untracked row takes the entry with the lowest stored count (the lowest index on a tie). The new row starts from that old count plus one.
- R5: Neighbours are not wrapped. An aggressor at row 0 yields only a request for row 1, and one at row 65535 yields only a request for row 65534.
- R6: Every refresh request accepted (`req_valid` and `req_ready` high at a clock edge) is counted as an activation of the refreshed row, and it can trigger further requests for that row's neighbours.
- R7: An accepted refresh is counted on the first later cycle with no activation, and activations go first. From the cycle after an accept until the refresh has been counted, `req_valid` is low.
- R8: `window_tick` clears every count. An activation in the tick cycle counts as 1. A row that misses in that cycle still replaces the entry with the lowest count stored before the clear.
- R9: Once `req_valid` is high, `req_valid` and `req_row` hold their values until the request is accepted.
- R10: The queue holds 4 requests. A request pushed while the queue is full is dropped, with row-1 kept before row+1. `overflow_err` then goes high and stays high until reset.
- R11: `threshold` is a 16-bit value, and any value from 1 to 65535 (for example 1000) is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | A row activation happens this cycle |
| act_row | input | 16 | Row being activated |
| window_tick | input | 1 | Start of a new refresh window; clears counts |
| threshold | input | 16 | Activation count that marks a row as an aggressor |
| req_valid | output | 1 | A targeted refresh request is offered |
| req_row | output | 16 | Victim row to refresh |
| req_ready | input | 1 | Scheduler accepts the offered request |
| overflow_err | output | 1 | Sticky: a request was dropped on a full queue |

## Verification
Two events can compete for the single table update port in one cycle: an external activation and the counting of a refresh that was just accepted. The bench provokes this collision by keeping activations of another row running on the cycles right after an accept. It then judges that the offer line stays low while the refresh waits. It also judges that the refresh is counted once the activations stop and that its later effects appear in order. A second collision, a window tick in the same cycle as an activation, is judged by a reference model that follows every cycle and predicts each offered request row.

// File: rtl/rht_pkg.sv
package rht_pkg;
  parameter int unsigned ROW_W      = 16;
  parameter int unsigned ENTRIES    = 16;
  parameter int unsigned CNT_W      = 16;
  parameter int unsigned FIFO_DEPTH = 4;

  typedef logic [ROW_W-1:0] row_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/rht_table.sv
module rht_table #(
  parameter int unsigned ENTRIES = rht_pkg::ENTRIES,
  parameter int unsigned ROW_W   = rht_pkg::ROW_W,
  parameter int unsigned CNT_W   = rht_pkg::CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic [ROW_W-1:0]         ev_row,
  input  logic                     clear,
  input  logic [CNT_W-1:0]         threshold,
  output logic                     fire,
  output logic [ROW_W-1:0]         fire_row,
  output logic [ENTRIES*CNT_W-1:0] cnt_flat
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ROW_W-1:0] rows_q [ENTRIES];
  logic [CNT_W-1:0] cnts_q [ENTRIES];
  logic [ROW_W-1:0] rows_n [ENTRIES];
  logic [CNT_W-1:0] cnts_n [ENTRIES];

  logic             hit;
  logic [IDX_W-1:0] hit_idx, min_idx, sel;
  logic [CNT_W-1:0] min_cnt, base, bump;
  logic             upd_en;

  // lookup and victim selection
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && rows_q[i] == ev_row) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    min_idx = '0;
    min_cnt = cnts_q[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (cnts_q[i] < min_cnt) begin
        min_cnt = cnts_q[i];
        min_idx = IDX_W'(i);
      end
    end
    sel  = hit ? hit_idx : min_idx;
    base = clear ? '0 : cnts_q[sel];
    bump = (&base) ? base : base + 1'b1;
    fire = ev_valid && (bump >= threshold);
  end

  assign fire_row = ev_row;
  assign upd_en   = ev_valid | clear;

  // next state
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rows_n[i] = rows_q[i];
      cnts_n[i] = clear ? '0 : cnts_q[i];
    end
    if (ev_valid) begin
      rows_n[sel] = ev_row;
      cnts_n[sel] = fire ? '0 : bump;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        rows_q[i] <= '0;
        cnts_q[i] <= '0;
      end
    end else if (upd_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        rows_q[i] <= rows_n[i];
        cnts_q[i] <= cnts_n[i];
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign cnt_flat[g*CNT_W +: CNT_W] = cnts_q[g];
  end
endmodule

// File: rtl/rht_fifo.sv
module rht_fifo #(
  parameter int unsigned DEPTH  = rht_pkg::FIFO_DEPTH,
  parameter int unsigned W      = rht_pkg::ROW_W,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_a,
  input  logic [W-1:0]      data_a,
  input  logic              push_b,
  input  logic [W-1:0]      data_b,
  input  logic              pop,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic              overflow,
  output logic [FILL_W-1:0] fill
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [W-1:0]      mem_q [DEPTH];
  logic [W-1:0]      mem_n [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_n, rptr_q, rptr_n;
  logic [FILL_W-1:0] fill_q, fill_n;
  logic              ovf_q, ovf_n;
  logic              take_a, take_b, en;
  int                space;

  always_comb begin
    space  = int'(DEPTH) - int'(fill_q) + int'(pop);
    take_a = push_a && (space > 0);
    take_b = push_b && ((space - int'(take_a)) > 0);
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem_q[i];
    if (take_a) mem_n[wptr_q] = data_a;
    if (take_b) mem_n[wptr_q + PTR_W'(take_a)] = data_b;
    wptr_n = wptr_q + PTR_W'(take_a) + PTR_W'(take_b);
    rptr_n = rptr_q + PTR_W'(pop);
    fill_n = FILL_W'(int'(fill_q) + int'(take_a) + int'(take_b) - int'(pop));
    ovf_n  = ovf_q | (push_a & ~take_a) | (push_b & ~take_b);
  end

  assign en = push_a | push_b | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      fill_q <= fill_n;
      ovf_q  <= ovf_n;
    end
  end

  assign out_valid = (fill_q != '0);
  assign out_data  = mem_q[rptr_q];
  assign overflow  = ovf_q;
  assign fill      = fill_q;
endmodule

// File: rtl/rht_tracker.sv
module rht_tracker #(
  parameter int unsigned ROW_W      = rht_pkg::ROW_W,
  parameter int unsigned ENTRIES    = rht_pkg::ENTRIES,
  parameter int unsigned CNT_W      = rht_pkg::CNT_W,
  parameter int unsigned FIFO_DEPTH = rht_pkg::FIFO_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  input  logic             window_tick,
  input  logic [CNT_W-1:0] threshold,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row,
  input  logic             req_ready,
  output logic             overflow_err
);
  localparam int unsigned FILL_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

  logic                     pend_v, pend_v_n;
  logic [ROW_W-1:0]         pend_row, pend_row_n;
  logic                     fifo_ne;
  logic [ROW_W-1:0]         fifo_row;
  logic [FILL_W-1:0]        fifo_fill;
  logic                     accept, pend_en;
  logic                     ev_valid;
  logic [ROW_W-1:0]         ev_row;
  logic                     fire;
  logic [ROW_W-1:0]         fire_row;
  logic                     push_lo, push_hi;
  logic [ENTRIES*CNT_W-1:0] cnt_flat;

  // offer only when no accepted refresh still waits to be counted
  assign req_valid = fifo_ne & ~pend_v;
  assign req_row   = fifo_row;
  assign accept    = req_valid & req_ready;

  // activations take the update port first
  assign ev_valid = act_valid | pend_v;
  assign ev_row   = act_valid ? act_row : pend_row;

  always_comb begin
    pend_v_n   = accept | (pend_v & act_valid);
    pend_row_n = accept ? fifo_row : pend_row;
  end
  assign pend_en = accept | pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_row <= '0;
    end else if (pend_en) begin
      pend_v   <= pend_v_n;
      pend_row <= pend_row_n;
    end
  end

  rht_table #(.ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_row    (ev_row),
    .clear     (window_tick),
    .threshold (threshold),
    .fire      (fire),
    .fire_row  (fire_row),
    .cnt_flat  (cnt_flat)
  );

  assign push_lo = fire && (fire_row != '0);
  assign push_hi = fire && (fire_row != ROW_MAX);

  rht_fifo #(.DEPTH(FIFO_DEPTH), .W(ROW_W), .FILL_W(FILL_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_a    (push_lo),
    .data_a    (fire_row - 1'b1),
    .push_b    (push_hi),
    .data_b    (fire_row + 1'b1),
    .pop       (accept),
    .out_valid (fifo_ne),
    .out_data  (fifo_row),
    .overflow  (overflow_err),
    .fill      (fifo_fill)
  );
endmodule

// File: rtl/rht_tracker_chk.sv
module rht_tracker_chk #(
  parameter int unsigned ROW_W      = 16,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned FILL_W     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     act_valid,
  input logic                     window_tick,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [ROW_W-1:0]         req_row,
  input logic                     overflow_err,
  input logic                     pend_v,
  input logic [ENTRIES*CNT_W-1:0] cnt_flat,
  input logic [FILL_W-1:0]        fifo_fill
);
  logic any_cnt;
  assign any_cnt = |cnt_flat;

  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!req_valid && !overflow_err && !any_cnt));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));

  p_gap_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= FILL_W'(FIFO_DEPTH));

  p_tick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (window_tick && !act_valid && !pend_v) |=> !any_cnt);
endmodule

bind rht_tracker rht_tracker_chk #(
  .ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W),
  .FIFO_DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .act_valid    (act_valid),
  .window_tick  (window_tick),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_row      (req_row),
  .overflow_err (overflow_err),
  .pend_v       (pend_v),
  .cnt_flat     (cnt_flat),
  .fifo_fill    (fifo_fill)
);

// File: tb/rht_tracker_test.sv
`timescale 1ns/1ps
module rht_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_valid = 1'b0;
  logic [15:0] act_row = '0;
  logic        window_tick = 1'b0;
  logic [15:0] threshold = 16'd4;
  logic        req_ready = 1'b0;
  logic        req_valid;
  logic [15:0] req_row;
  logic        overflow_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rht_tracker uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .window_tick(window_tick), .threshold(threshold),
    .req_valid(req_valid), .req_row(req_row), .req_ready(req_ready),
    .overflow_err(overflow_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  int m_row [16];
  int m_cnt [16];
  bit m_pv;
  int m_prow;
  bit m_err;
  int exp_q [$];
  int got_q [$];
  bit prev_v, prev_rdy;
  int prev_row;

  task automatic model_event(input bit valid, input int row, input bit tick);
    int hit, mi, sel, base, nb, space;
    bit fire;
    hit = -1;
    for (int i = 0; i < 16; i++) if (hit < 0 && m_row[i] == row) hit = i;
    mi = 0;
    for (int i = 1; i < 16; i++) if (m_cnt[i] < m_cnt[mi]) mi = i;
    sel  = (hit >= 0) ? hit : mi;
    base = tick ? 0 : m_cnt[sel];
    if (tick) for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    if (valid) begin
      nb   = (base == 65535) ? base : base + 1;
      fire = (nb >= int'(threshold));
      m_row[sel] = row;
      m_cnt[sel] = fire ? 0 : nb;
      if (fire) begin
        space = 4 - exp_q.size();
        if (row != 0) begin
          if (space > 0) begin exp_q.push_back(row - 1); space--; end
          else m_err = 1'b1;
        end
        if (row != 65535) begin
          if (space > 0) exp_q.push_back(row + 1);
          else m_err = 1'b1;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_row[i] = 0; m_cnt[i] = 0; end
      m_pv = 0; m_prow = 0; m_err = 0; exp_q.delete();
      prev_v = 0; prev_rdy = 0; prev_row = 0;
    end else begin
      bit exp_v, acc, ev_v;
      int ev_r;
      exp_v = (exp_q.size() > 0) && !m_pv;
      chk(req_valid == exp_v, "R7 offer", int'(req_valid), int'(exp_v));
      chk(overflow_err == m_err, "R10 err", int'(overflow_err), int'(m_err));
      if (prev_v && !prev_rdy)
        chk(req_valid && int'(req_row) == prev_row, "R9 hold", int'(req_row), prev_row);
      prev_v = req_valid; prev_rdy = req_ready; prev_row = int'(req_row);
      acc = req_valid && req_ready;
      if (acc) begin
        got_q.push_back(int'(req_row));
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(int'(req_row) == e, "R2 row", int'(req_row), e);
        end else chk(1'b0, "R2 unexpected", int'(req_row), -1);
      end
      ev_v = act_valid || m_pv;
      ev_r = act_valid ? int'(act_row) : m_prow;
      if (acc) begin m_pv = 1; m_prow = int'(req_row); end
      else if (m_pv && !act_valid) m_pv = 0;
      model_event(ev_v, ev_r, window_tick);
    end
  end

  // ---------------- driver tasks ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic act(input int row);
    act_valid = 1'b1; act_row = 16'(row);
    step();
    act_valid = 1'b0;
  endtask

  task automatic do_reset();
    act_valid = 0; window_tick = 0; req_ready = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
  endtask

  task automatic drain();
    req_ready = 1'b1;
    for (int k = 0; k < 400 && (exp_q.size() > 0 || m_pv); k++) step();
    idle(2);
  endtask

  function automatic bit got_has(input int from, input int row);
    for (int i = from; i < got_q.size(); i++) if (got_q[i] == row) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    int b;
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk(req_valid == 0, "R1 valid", int'(req_valid), 0);
    chk(overflow_err == 0, "R1 err", int'(overflow_err), 0);
    step();

    // R2 basic hammer
    threshold = 4; req_ready = 1;
    b = got_q.size();
    repeat (4) act(100);
    idle(8);
    chk(got_q.size() - b == 2, "R2 count", got_q.size() - b, 2);
    if (got_q.size() - b == 2) begin
      chk(got_q[b] == 99, "R2 first", got_q[b], 99);
      chk(got_q[b+1] == 101, "R2 second", got_q[b+1], 101);
    end

    // R3 decoy interleave
    do_reset(); threshold = 6; req_ready = 1;
    b = got_q.size();
    for (int k = 0; k < 6; k++) begin act(200); act(300 + k % 4); end
    idle(8);
    chk(got_has(b, 199) && got_has(b, 201), "R3 aggressor", got_q.size() - b, 2);

    // R4 replacement with carried count
    do_reset(); threshold = 3; req_ready = 1;
    for (int i = 0; i < 16; i++) begin act(1000 + i); act(1000 + i); end
    idle(2);
    b = got_q.size();
    chk(got_q.size() - b == 0, "R4 none yet", 0, 0);
    act(2000);
    idle(8);
    chk(got_has(b, 1999) && got_has(b, 2001), "R4 carry", got_q.size() - b, 2);

    // R5 address edges
    do_reset(); threshold = 2; req_ready = 1;
    b = got_q.size();
    act(0); act(0); idle(6);
    chk(got_q.size() - b == 1 && got_q[b] == 1, "R5 low edge", got_q.size() - b, 1);
    b = got_q.size();
    act(65535); act(65535); idle(6);
    chk(got_q.size() - b == 1 && got_q[b] == 65534, "R5 high edge", got_q.size() - b, 1);

    // R6 second ring through feedback
    do_reset(); threshold = 2; req_ready = 1;
    b = got_q.size();
    act(500); act(500); idle(6);
    act(500); act(500);
    drain();
    chk(got_has(b, 498) && got_has(b, 502), "R6 second ring", got_q.size() - b, 6);

    // R7 activation collides with pending feedback
    do_reset(); threshold = 2; req_ready = 1;
    b = got_q.size();
    act(700); act(700);
    act_valid = 1; act_row = 900;
    step();
    @(negedge clk);
    chk(req_valid == 0, "R7 held off", int'(req_valid), 0);
    step();
    act_valid = 0;
    idle(6);
    chk(got_has(b, 699) && got_has(b, 701), "R7 both served", got_q.size() - b, 2);

    // R8 window tick
    do_reset(); threshold = 4; req_ready = 1;
    b = got_q.size();
    repeat (3) act(7);
    window_tick = 1; step(); window_tick = 0;
    repeat (3) act(7);
    idle(4);
    chk(got_q.size() - b == 0, "R8 cleared", got_q.size() - b, 0);
    act(7); idle(6);
    chk(got_has(b, 6) && got_has(b, 8), "R8 refire", got_q.size() - b, 2);
    b = got_q.size();
    repeat (2) act(30);
    act_valid = 1; act_row = 30; window_tick = 1; step();
    act_valid = 0; window_tick = 0;
    repeat (2) act(30);
    idle(4);
    chk(got_q.size() - b == 0, "R8 tick with act", got_q.size() - b, 0);

    // R10 overflow and R9 hold
    do_reset(); threshold = 1; req_ready = 0;
    b = got_q.size();
    act(10); act(20); act(30);
    idle(4);
    @(negedge clk);
    chk(overflow_err == 1, "R10 flagged", int'(overflow_err), 1);
    chk(req_valid == 1 && req_row == 9, "R9 head", int'(req_row), 9);
    threshold = 100;
    step();
    drain();
    chk(overflow_err == 1, "R10 sticky", int'(overflow_err), 1);
    chk(got_q.size() - b == 4 && got_q[b+3] == 21, "R10 kept", got_q.size() - b, 4);

    // R11 large threshold
    do_reset(); threshold = 1000; req_ready = 1;
    b = got_q.size();
    repeat (999) act(4000);
    idle(4);
    chk(got_q.size() - b == 0, "R11 below", got_q.size() - b, 0);
    act(4000); idle(6);
    chk(got_has(b, 3999) && got_has(b, 4001), "R11 at", got_q.size() - b, 2);

    // mixed traffic scored by the model
    do_reset(); threshold = 8;
    for (int k = 0; k < 3000; k++) begin
      act_valid   = ($urandom_range(0, 3) != 0);
      act_row     = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(0, 1) * 65535)
                                                : 16'(60 + $urandom_range(0, 5) * 2);
      window_tick = ($urandom_range(0, 199) == 0);
      req_ready   = ($urandom_range(0, 2) != 0);
      step();
    end
    act_valid = 0; window_tick = 0;
    threshold = 60000;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule